// File: doc/BRIEF.md
# Static memory bank timing sequencer

This block runs one chip-select bank of an asynchronous static memory bus. An internal requester raises a single read or write; the block latches it, then walks the external bus through five phases: address setup, chip-select setup, the strobe itself, chip-select hold and address hold. Each phase length comes from a per-bank timing word, counted in controller clock cycles. When the last hold phase ends, a one-cycle acknowledge returns, carrying read data for reads.

A four-bit attribute field selects how the bank is used. It picks a 16-bit or 8-bit data path, word-based or byte-based external addressing, stretching of the strobe by an active-low wait input, and per-lane byte strobes. This field sits in a bus-width register shared by all banks, at the slot given by a bank index parameter. A small write port programs both registers, and a select line reads either one back. Software can switch timing at run time, for example between a slow profile (setup and hold 15, access 31) and a fast one (setup and hold 1, access 11). An access always uses the values that were in force when it was accepted.

Top module: `srom_bank_seq`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane strobes are high (inactive), the data driver is off, acknowledge is low, the timing word reads back as the slow profile 0xFF1FFF00 and the bus-width register reads back its reset parameter.
- R2: Timing word fields: address setup in bits 31:28, chip-select setup in 27:24, access length in 20:16, chip-select hold in 15:12, address hold in 11:8; bits 23:21 and 7:0 are stored and read back but change no bus timing.
- R3: An accepted access shows address setup cycles with chip select high, then chip-select setup cycles with chip select low and no strobe, then the strobe cycles, then chip-select hold cycles with chip select low, then address hold cycles with chip select high; each count equals its field.
- R4: A phase whose field is zero takes no cycles, and the strobe phase lasts one cycle when its field is zero.
- R5: With cfg_sel=0 a write replaces the whole timing word; with cfg_sel=1 it replaces only bits 4*BANK_IDX+3:4*BANK_IDX of the bus-width register. Within that field, bit 0 selects a 16-bit bus, bit 1 byte addressing, bit 2 wait stretching and bit 3 lane strobes. cfg_rdata returns the register named by cfg_sel.
- R6: The external address is request address bits 14:1 on a 16-bit bus with word addressing, and bits 13:0 otherwise. It holds its value from the first cycle after acceptance through the end of the access.
- R7: Read data is sampled at the end of the last strobe cycle; on an 8-bit bus the response is the low byte zero-extended.
- R8: During a write the data driver is on exactly while chip select is low, carrying the request data; on an 8-bit bus, the low byte with the upper byte zero.
- R9: While chip select is low the active-low lane strobes are 00 when lane strobes are disabled, 10 on an 8-bit bus, and the inverted request byte enables otherwise; outside chip select they are 11.
- R10: With wait stretching on, the strobe stays low past its programmed length while the wait input is low, and rises at the second rising clock edge after the wait input is seen high.
- R11: With wait stretching off, the wait input has no effect on the strobe length.
- R12: Acknowledge is high for exactly one cycle, in the cycle after the last hold cycle. A request kept high during an access produces only one access.
- R13: A configuration write during an access leaves that access's timing unchanged and applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects timing word, 1 selects bus-width register |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | EXT_AW+1 | Byte address of the request |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data of the last read |
| mem_csn_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | EXT_AW | External address |
| mem_dout | output | DW | Write data toward the memory |
| mem_doe | output | 1 | Data driver enable |
| mem_ben_n | output | DW/8 | Lane strobes, active low |
| mem_din | input | DW | Read data from the memory |
| mem_wait_n | input | 1 | Wait request, active low |

## Verification
The bench builds the block with BANK_IDX=2 and a bus-width reset value of 0x98765021. Every slot except the tested one therefore holds nonzero bits that a careless write would disturb, and the tested slot sits away from bit 0. The address and data widths stay at 14 and 16. The timing fields are drawn small and often zero, so every pattern of skipped phases appears, and the wait release point is drawn on both sides of the programmed strobe length.

// File: rtl/srom_seq_pkg.sv
`timescale 1ns/1ps
package srom_seq_pkg;

  localparam int CNT_W = 5;

  typedef struct packed {
    logic lane_strb;
    logic wait_en;
    logic byte_addr;
    logic wide;
  } attr_t;

  typedef struct packed {
    logic [3:0]       acs;
    logic [3:0]       cos;
    logic [CNT_W-1:0] acc;
    logic [3:0]       coh;
    logic [3:0]       cah;
  } phase_len_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASET, PH_CSET, PH_ACC, PH_WAIT, PH_CHOLD, PH_AHOLD
  } phase_e;

  function automatic logic is_select(input phase_e p);
    return (p == PH_CSET) || (p == PH_ACC) || (p == PH_WAIT) || (p == PH_CHOLD);
  endfunction

  function automatic logic is_strobe(input phase_e p);
    return (p == PH_ACC) || (p == PH_WAIT);
  endfunction

  function automatic logic [CNT_W-1:0] load_for(input phase_e p, input phase_len_t t);
    logic [CNT_W-1:0] v;
    v = '0;
    case (p)
      PH_ASET:  v = CNT_W'(t.acs) - CNT_W'(1);
      PH_CSET:  v = CNT_W'(t.cos) - CNT_W'(1);
      PH_ACC:   v = (t.acc == '0) ? '0 : t.acc - CNT_W'(1);
      PH_CHOLD: v = CNT_W'(t.coh) - CNT_W'(1);
      PH_AHOLD: v = CNT_W'(t.cah) - CNT_W'(1);
      default:  v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/srom_cfg_regs.sv
`timescale 1ns/1ps
module srom_cfg_regs
  import srom_seq_pkg::*;
#(
  parameter int          BANK_IDX   = 0,
  parameter logic [31:0] RST_TIMING = 32'hFF1F_FF00,
  parameter logic [31:0] RST_WIDTH  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output phase_len_t  live_len,
  output attr_t       live_attr
);
  localparam int SLOT_LSB = 4 * BANK_IDX;

  logic [31:0] timing_q;
  logic [31:0] width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_q <= RST_TIMING;
      width_q  <= RST_WIDTH;
    end else if (cfg_wr) begin
      if (!cfg_sel) timing_q <= cfg_wdata;
      else          width_q[SLOT_LSB +: 4] <= cfg_wdata[SLOT_LSB +: 4];
    end
  end

  assign cfg_rdata    = cfg_sel ? width_q : timing_q;
  assign live_len.acs = timing_q[31:28];
  assign live_len.cos = timing_q[27:24];
  assign live_len.acc = timing_q[20:16];
  assign live_len.coh = timing_q[15:12];
  assign live_len.cah = timing_q[11:8];
  assign live_attr    = attr_t'(width_q[SLOT_LSB +: 4]);

endmodule

// File: rtl/srom_phase_seq.sv
`timescale 1ns/1ps
module srom_phase_seq
  import srom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  phase_len_t live_len,
  input  logic       live_wait_en,
  input  logic       mem_wait_n,
  output phase_e     phase,
  output logic       accept,
  output logic       capture,
  output logic       ack
);
  phase_e           ph_q, ph_d, nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_len_t       len_q, len_cur;
  logic             wait_en_q, waitn_q, ack_q, done, go;
  phase_e           tgt_start, tgt_sel, tgt_hold, tgt_tail;

  assign len_cur = (ph_q == PH_IDLE) ? live_len : len_q;
  assign accept  = (ph_q == PH_IDLE) && req_valid && !ack_q;

  always_comb begin
    tgt_sel   = (len_cur.cos != '0) ? PH_CSET  : PH_ACC;
    tgt_start = (len_cur.acs != '0) ? PH_ASET  : tgt_sel;
    tgt_tail  = (len_cur.cah != '0) ? PH_AHOLD : PH_IDLE;
    tgt_hold  = (len_cur.coh != '0) ? PH_CHOLD : tgt_tail;
  end

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    nxt     = ph_q;
    go      = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    case (ph_q)
      PH_IDLE: if (accept) begin nxt = tgt_start; go = 1'b1; end
      PH_ASET:
        if (cnt_q == '0) begin nxt = tgt_sel; go = 1'b1; end
        else cnt_d = cnt_q - CNT_W'(1);
      PH_CSET:
        if (cnt_q == '0) begin nxt = PH_ACC; go = 1'b1; end
        else cnt_d = cnt_q - CNT_W'(1);
      PH_ACC:
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else if (wait_en_q && !waitn_q) ph_d = PH_WAIT;
        else begin capture = 1'b1; nxt = tgt_hold; go = 1'b1; end
      PH_WAIT:
        if (waitn_q) begin capture = 1'b1; nxt = tgt_hold; go = 1'b1; end
      PH_CHOLD:
        if (cnt_q == '0) begin nxt = tgt_tail; go = 1'b1; end
        else cnt_d = cnt_q - CNT_W'(1);
      PH_AHOLD:
        if (cnt_q == '0) begin nxt = PH_IDLE; go = 1'b1; end
        else cnt_d = cnt_q - CNT_W'(1);
      default: begin nxt = PH_IDLE; go = 1'b1; end
    endcase
    if (go) begin
      ph_d  = nxt;
      cnt_d = load_for(nxt, len_cur);
      done  = (nxt == PH_IDLE) && (ph_q != PH_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      wait_en_q <= 1'b0;
      waitn_q   <= 1'b1;
      ack_q     <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      waitn_q <= mem_wait_n;
      ack_q   <= done;
      if (accept) begin
        len_q     <= live_len;
        wait_en_q <= live_wait_en;
      end
    end
  end

  assign phase = ph_q;
  assign ack   = ack_q;

endmodule

// File: rtl/srom_bus_path.sv
`timescale 1ns/1ps
module srom_bus_path
  import srom_seq_pkg::*;
#(
  parameter int EXT_AW = 14,
  parameter int DW     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                capture,
  input  phase_e              phase,
  input  attr_t               live_attr,
  input  logic                req_write,
  input  logic [EXT_AW:0]     req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [DW/8-1:0]     req_be,
  input  logic [DW-1:0]       mem_din,
  output logic                mem_csn_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [EXT_AW-1:0]   mem_addr,
  output logic [DW-1:0]       mem_dout,
  output logic                mem_doe,
  output logic [DW/8-1:0]     mem_ben_n,
  output logic [DW-1:0]       rsp_rdata
);
  localparam int LANES = DW / 8;
  localparam int NW    = 8;

  logic              wr_q, wide_q, sel, stb;
  logic [EXT_AW-1:0] addr_q, addr_map;
  logic [DW-1:0]     dout_q, dout_map, rdata_q;
  logic [LANES-1:0]  ben_q, ben_map;

  always_comb begin
    addr_map = (live_attr.wide && !live_attr.byte_addr) ? req_addr[EXT_AW:1]
                                                        : req_addr[EXT_AW-1:0];
    dout_map = live_attr.wide ? req_wdata : {{(DW-NW){1'b0}}, req_wdata[NW-1:0]};
    if (!live_attr.lane_strb)  ben_map = '0;
    else if (!live_attr.wide)  ben_map = {{(LANES-1){1'b1}}, 1'b0};
    else                       ben_map = ~req_be;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
      ben_q   <= '1;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        wr_q   <= req_write;
        wide_q <= live_attr.wide;
        addr_q <= addr_map;
        dout_q <= dout_map;
        ben_q  <= ben_map;
      end
      if (capture && !wr_q)
        rdata_q <= wide_q ? mem_din : {{(DW-NW){1'b0}}, mem_din[NW-1:0]};
    end
  end

  assign sel       = is_select(phase);
  assign stb       = is_strobe(phase);
  assign mem_csn_n = !sel;
  assign mem_oe_n  = !(stb && !wr_q);
  assign mem_we_n  = !(stb && wr_q);
  assign mem_doe   = sel && wr_q;
  assign mem_ben_n = sel ? ben_q : '1;
  assign mem_addr  = addr_q;
  assign mem_dout  = dout_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/srom_bank_seq.sv
`timescale 1ns/1ps
module srom_bank_seq
  import srom_seq_pkg::*;
#(
  parameter int          BANK_IDX   = 0,
  parameter int          EXT_AW     = 14,
  parameter int          DW         = 16,
  parameter logic [31:0] RST_TIMING = 32'hFF1F_FF00,
  parameter logic [31:0] RST_WIDTH  = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [EXT_AW:0]    req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [DW/8-1:0]    req_be,
  output logic               req_ack,
  output logic [DW-1:0]      rsp_rdata,
  output logic               mem_csn_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [EXT_AW-1:0]  mem_addr,
  output logic [DW-1:0]      mem_dout,
  output logic               mem_doe,
  output logic [DW/8-1:0]    mem_ben_n,
  input  logic [DW-1:0]      mem_din,
  input  logic               mem_wait_n
);
  phase_len_t live_len;
  attr_t      live_attr;
  phase_e     phase;
  logic       accept, capture;

  srom_cfg_regs #(
    .BANK_IDX(BANK_IDX), .RST_TIMING(RST_TIMING), .RST_WIDTH(RST_WIDTH)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .live_len(live_len), .live_attr(live_attr)
  );

  srom_phase_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .live_len(live_len),
    .live_wait_en(live_attr.wait_en), .mem_wait_n(mem_wait_n),
    .phase(phase), .accept(accept), .capture(capture), .ack(req_ack)
  );

  srom_bus_path #(.EXT_AW(EXT_AW), .DW(DW)) u_path (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture), .phase(phase),
    .live_attr(live_attr), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .mem_din(mem_din),
    .mem_csn_n(mem_csn_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_ben_n(mem_ben_n), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/srom_bank_seq_checker.sv
`timescale 1ns/1ps
module srom_bank_seq_checker #(
  parameter int EXT_AW = 14,
  parameter int DW     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ack,
  input logic              mem_csn_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [EXT_AW-1:0] mem_addr,
  input logic              mem_doe,
  input logic [DW/8-1:0]   mem_ben_n
);
  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  assert_ack_deselected_R12: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> mem_csn_n);

  assert_strobe_inside_select_R3: assert property (@(posedge clk) disable iff (rst)
    mem_csn_n |-> (mem_oe_n && mem_we_n));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_csn_n |=> (mem_csn_n || $stable(mem_addr)));

  assert_drive_window_R8: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> !mem_csn_n);

  assert_write_driven_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_doe);

  assert_lanes_idle_R9: assert property (@(posedge clk) disable iff (rst)
    mem_csn_n |-> (mem_ben_n == '1));
endmodule

bind srom_bank_seq srom_bank_seq_checker #(.EXT_AW(EXT_AW), .DW(DW)) u_checker (
  .clk(clk), .rst(rst), .req_ack(req_ack), .mem_csn_n(mem_csn_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
  .mem_doe(mem_doe), .mem_ben_n(mem_ben_n)
);

// File: tb/srom_bank_seq_bench.sv
`timescale 1ns/1ps
module srom_bank_seq_bench;
  localparam int          BIDX = 2;
  localparam logic [31:0] RW   = 32'h9876_5021;
  localparam logic [31:0] SLOW = 32'hFF1F_FF00;
  localparam logic [31:0] FAST = 32'h110B_1100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_write = 1'b0, req_ack;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dout, mem_din = '0;
  logic [1:0] req_be = 2'b11, mem_ben_n;
  logic mem_csn_n, mem_oe_n, mem_we_n, mem_doe, mem_wait_n = 1'b1;
  logic [13:0] mem_addr;

  srom_bank_seq #(.BANK_IDX(BIDX), .RST_TIMING(SLOW), .RST_WIDTH(RW)) u_srom_bank_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_csn_n(mem_csn_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_ben_n(mem_ben_n), .mem_din(mem_din), .mem_wait_n(mem_wait_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  logic [31:0] tim_model = SLOW, width_model = RW;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int acc_len(input logic [31:0] t);
    return (t[20:16] == 5'd0) ? 1 : int'(t[20:16]);
  endfunction
  function automatic logic [13:0] exp_addr(input logic [3:0] at, input logic [14:0] a);
    return (at[0] && !at[1]) ? a[14:1] : a[13:0];
  endfunction
  function automatic logic [1:0] exp_ben(input logic [3:0] at, input logic [1:0] be);
    if (!at[3]) return 2'b00;
    if (!at[0]) return 2'b10;
    return ~be;
  endfunction
  function automatic logic [15:0] narrow_fix(input logic [3:0] at, input logic [15:0] d);
    return at[0] ? d : {8'h00, d[7:0]};
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!sel) tim_model = d;
    else width_model[4*BIDX +: 4] = d[4*BIDX +: 4];
  endtask

  task automatic set_attr(input logic [3:0] at);
    logic [31:0] d;
    d = $urandom;
    d[4*BIDX +: 4] = at;
    cfg_write(1'b1, d);
  endtask

  task automatic check_cfg(input string req);
    @(negedge clk);
    cfg_sel = 1'b0; #1 check(req, cfg_rdata, tim_model);
    cfg_sel = 1'b1; #1 check(req, cfg_rdata, width_model);
  endtask

  // rel: strobe-low count at which the wait input is released (-1: never pulled low)
  task automatic run_access(input string tag, input logic wr, input logic [14:0] a,
                            input logic [15:0] wd, input logic [1:0] be, input int rel,
                            input logic mid_cfg, input logic [31:0] mid_val);
    logic [3:0]  at;
    logic [31:0] t;
    logic [15:0] rdv;
    int cnt[5];
    int seg, n, x, exp_acc, falls;
    logic prev_csn, saw_ack;
    at = width_model[4*BIDX +: 4];
    t = tim_model;
    rdv = 16'($urandom);
    foreach (cnt[i]) cnt[i] = 0;
    seg = 0; falls = 0; prev_csn = 1'b1; saw_ack = 1'b0;
    x = acc_len(t);
    exp_acc = (at[2] && rel >= x) ? rel + 1 : x;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    mem_din = rdv; mem_wait_n = (rel >= 0) ? 1'b0 : 1'b1;
    for (n = 1; n <= 400; n++) begin
      @(negedge clk);
      if (mid_cfg && n == 2) begin cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = mid_val; end
      if (mid_cfg && n == 3) cfg_wr = 1'b0;
      if (req_ack) begin saw_ack = 1'b1; break; end
      if (!mem_oe_n || !mem_we_n) seg = 2;
      else if (!mem_csn_n) seg = (seg >= 2) ? 3 : 1;
      else seg = (seg >= 1) ? 4 : 0;
      cnt[seg]++;
      if (prev_csn && !mem_csn_n) falls++;
      prev_csn = mem_csn_n;
      check("R6", 32'(mem_addr), 32'(exp_addr(at, a)));
      if (!mem_csn_n) begin
        check("R9", 32'(mem_ben_n), 32'(exp_ben(at, be)));
        check("R8", 32'(mem_doe), 32'(wr));
        if (wr) check("R8", 32'(mem_dout), 32'(narrow_fix(at, wd)));
      end else begin
        check("R8", 32'(mem_doe), 32'd0);
        check("R9", 32'(mem_ben_n), 32'h3);
      end
      if (seg == 2 && rel >= 0 && cnt[2] == rel) mem_wait_n = 1'b1;
      if (seg >= 3 && !wr) mem_din = ~rdv;
    end
    cfg_wr = 1'b0;
    req_valid = 1'b0; mem_wait_n = 1'b1;
    check("R12", 32'(saw_ack), 32'd1);
    check(tag, 32'(cnt[0]), 32'(t[31:28]));
    check(tag, 32'(cnt[1]), 32'(t[27:24]));
    check(tag, 32'(cnt[2]), 32'(exp_acc));
    check(tag, 32'(cnt[3]), 32'(t[15:12]));
    check(tag, 32'(cnt[4]), 32'(t[11:8]));
    check("R12", 32'(falls), 32'd1);
    if (!wr) check("R7", 32'(rsp_rdata), 32'(narrow_fix(at, rdv)));
    @(negedge clk);
    check("R12", 32'(req_ack), 32'd0);
    check("R12", 32'(mem_csn_n), 32'd1);
    if (mid_cfg) tim_model = mid_val;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    int x;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 32'(mem_csn_n), 32'd1);
    check("R1", 32'(mem_oe_n), 32'd1);
    check("R1", 32'(mem_we_n), 32'd1);
    check("R1", 32'(mem_ben_n), 32'h3);
    check("R1", 32'(mem_doe), 32'd0);
    check("R1", 32'(req_ack), 32'd0);
    check_cfg("R1");

    // R5: only this bank's slot changes
    cfg_write(1'b1, 32'hFFFF_FFFF);
    check_cfg("R5");
    check("R5", cfg_rdata, 32'h9876_5F21);
    cfg_write(1'b1, 32'h0000_0100);
    check_cfg("R5");

    // R3: slow profile read, 16-bit word addressing
    run_access("R3", 1'b0, 15'h5A5B, 16'h0, 2'b11, -1, 1'b0, 32'h0);
    // R13: timing rewritten mid-access, then the new timing applies
    run_access("R13", 1'b1, 15'h1234, 16'hBEEF, 2'b11, -1, 1'b1, FAST);
    run_access("R13", 1'b0, 15'h0777, 16'h0, 2'b11, -1, 1'b0, 32'h0);

    // R9 / R6: byte addressing with lane strobes
    set_attr(4'b1011);
    run_access("R3", 1'b1, 15'h7FFF, 16'hA55A, 2'b01, -1, 1'b0, 32'h0);
    run_access("R3", 1'b1, 15'h0002, 16'hC3C3, 2'b10, -1, 1'b0, 32'h0);
    // R7 / R8: 8-bit bus
    set_attr(4'b1000);
    run_access("R3", 1'b1, 15'h4321, 16'h9C7E, 2'b11, -1, 1'b0, 32'h0);
    run_access("R3", 1'b0, 15'h4321, 16'h0, 2'b11, -1, 1'b0, 32'h0);

    // R4: zero-length phases
    set_attr(4'b0001);
    cfg_write(1'b0, 32'h0000_0000);
    run_access("R4", 1'b0, 15'h0100, 16'h0, 2'b11, -1, 1'b0, 32'h0);
    run_access("R4", 1'b1, 15'h0101, 16'h1357, 2'b11, -1, 1'b0, 32'h0);
    cfg_write(1'b0, 32'h0003_0000);
    run_access("R4", 1'b0, 15'h0102, 16'h0, 2'b11, -1, 1'b0, 32'h0);
    // R2: only the defined fields matter
    cfg_write(1'b0, 32'h12E2_31FF);
    run_access("R2", 1'b0, 15'h2222, 16'h0, 2'b11, -1, 1'b0, 32'h0);
    check_cfg("R2");

    // R10 / R11: wait stretching
    cfg_write(1'b0, FAST);
    x = acc_len(FAST);
    set_attr(4'b0101);
    run_access("R10", 1'b0, 15'h0F0F, 16'h0, 2'b11, -1, 1'b0, 32'h0);
    run_access("R10", 1'b0, 15'h0F0F, 16'h0, 2'b11, x, 1'b0, 32'h0);
    run_access("R10", 1'b1, 15'h0F0F, 16'h2468, 2'b11, x + 3, 1'b0, 32'h0);
    run_access("R10", 1'b0, 15'h0F0F, 16'h0, 2'b11, 2, 1'b0, 32'h0);
    set_attr(4'b0001);
    run_access("R11", 1'b0, 15'h0F0F, 16'h0, 2'b11, x + 3, 1'b0, 32'h0);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      t = $urandom;
      t[31:28] = 4'($urandom_range(0, 3));
      t[27:24] = 4'($urandom_range(0, 3));
      t[20:16] = 5'($urandom_range(0, 6));
      t[15:12] = 4'($urandom_range(0, 3));
      t[11:8]  = 4'($urandom_range(0, 3));
      cfg_write(1'b0, t);
      set_attr(4'($urandom_range(0, 15)));
      x = acc_len(t);
      run_access("R3", 1'($urandom), 15'($urandom), 16'($urandom), 2'($urandom),
                 ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(1, x + 4)),
                 1'b0, 32'h0);
    end
    check_cfg("R5");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule